// File: doc/BRIEF.md
# Three-Channel Interval Timer with PWM Outputs

This peripheral carries three independent up-counters. Each one can run as a pulse-width modulator. A per-channel interval value fixes the period and a per-channel match value fixes the point in the period where the output level changes. Software programs the block over a simple single-cycle register bus. Writes take effect on the clock edge that samples them. Read data is combinational while the read strobe is high.

Each channel has a power-of-two prescaler, one waveform output and one interrupt line. The interrupt line is driven by two sticky event flags: an interval wrap and a match hit. Each flag is gated by an enable bit, and reading the status register clears the flags. A self-clearing restart bit lets software put the count back to zero without stopping the channel.

Top module: `tri_timer_pwm`

## Requirements
- R1: After reset, every counter-control register reads 0x21 (halted, waveform off), every count, status and enable register reads 0, and all waveform and interrupt outputs are low.
- R2: Channel n's registers sit at a base offset plus 4*n. The base offsets are: clock control 0x00, counter control 0x0C, count 0x18 (read only), interval 0x24, match 0x30, interrupt status 0x54, interrupt enable 0x60. Written values read back, and a write to one channel leaves the other channels unchanged.
- R3: With counter-control bit 1 set and bit 0 clear, the count advances by one per prescaler tick from 0 up to the interval value, then returns to 0 on the next tick. Without bit 1, it wraps from 2^CNT_W-1 to 0.
- R4: While counter-control bit 0 is set, the count does not change, except through a restart.
- R5: Clock-control bit 0 enables the prescaler, and bits 4:1 hold N. When the prescaler is enabled, the count advances once every 2^(N+1) clocks. When it is disabled, the count advances every clock. Bit 5 is stored and read back.
- R6: With counter-control bit 3 set, bit 5 clear and bit 6 clear, the waveform output is high while the count is below the match value and low otherwise. The output follows the count on the same edge.
- R7: Counter-control bit 6 inverts the waveform level.
- R8: Counter-control bit 5 is an active-low waveform enable. While it is set, the output is held low whatever the polarity.
- R9: Status bit 0 sets when the count wraps to 0. Status bit 1 sets when the count reaches the match value while match mode is on. A read of the status register clears it.
- R10: A channel's interrupt output is high exactly when one of its status bits is set together with the same bit in its enable register.
- R11: Writing 1 to counter-control bit 4 forces the count to 0 and restarts the prescaler on that edge. The bit always reads back as 0.
- R12: If a status read and a new event fall on the same edge, the new event's bit stays set after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe; a status read clears at the edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is active |
| wave_o | output | NUM_CH | Waveform output, one per channel |
| irq_o | output | NUM_CH | Interrupt line, one per channel |

## Verification
The status register can be read and cleared on the same edge where the counter wraps. In that case the clear and the set compete for the same flag bit. The bench provokes this by starting a channel with a restart, counting edges to the wrap, and placing a status read exactly on that edge. The read must return the old value (no wrap yet). The next read must show the wrap bit, and the read after that must show it cleared. Interrupt masking is judged at the same moment, because that channel's enable is left at zero.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int BUS_W     = 32;
  localparam int CH_STRIDE = 4;
  localparam int SEL_W     = 4;

  localparam int OFS_CLK   = 'h00;
  localparam int OFS_CTRL  = 'h0C;
  localparam int OFS_CNT   = 'h18;
  localparam int OFS_INTV  = 'h24;
  localparam int OFS_MATCH = 'h30;
  localparam int OFS_ISR   = 'h54;
  localparam int OFS_IER   = 'h60;

  // clock control, bit 5 down to bit 0
  typedef struct packed {
    logic             src_sel;
    logic [SEL_W-1:0] div_sel;
    logic             div_en;
  } clk_ctrl_t;

  // counter control, bit 6 down to bit 0
  typedef struct packed {
    logic wave_inv;
    logic wave_off;
    logic restart;
    logic match_en;
    logic spare;
    logic intv_en;
    logic halt;
  } cnt_ctrl_t;

  localparam cnt_ctrl_t CTRL_RST = 7'b010_0001;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             div_en,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int PW = 1 << SEL_W;
  localparam logic [SEL_W-1:0] TOP_SEL = '1;
  localparam logic [PW-1:0]    ONES    = '1;

  logic [PW-1:0] pc_q, pc_d, limit;
  logic          at_limit;

  always_comb begin
    limit    = ONES >> (TOP_SEL - div_sel);
    at_limit = (pc_q == limit);
    tick     = run && (!div_en || at_limit);
    pc_d     = pc_q;
    if (restart) begin
      pc_d = '0;
    end else if (run && div_en) begin
      pc_d = at_limit ? '0 : pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/tt_channel.sv
module tt_channel import tt_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  cnt_ctrl_t        ctrl,
  input  logic [CNT_W-1:0] intv,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] count,
  output logic             wave,
  output logic             wrap_evt,
  output logic             match_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wave_q, wave_d, at_top;

  always_comb begin
    cnt_d     = cnt_q;
    wrap_evt  = 1'b0;
    match_evt = 1'b0;
    at_top    = (ctrl.intv_en && cnt_q == intv) || (cnt_q == CNT_MAX);
    if (restart) begin
      cnt_d = '0;
    end else if (!ctrl.halt && tick) begin
      if (at_top) begin
        cnt_d    = '0;
        wrap_evt = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      match_evt = ctrl.match_en && (cnt_d == match_val);
    end
    wave_d = !ctrl.wave_off &&
             ((ctrl.match_en && (cnt_d < match_val)) ^ ctrl.wave_inv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wave_q <= wave_d;
    end
  end

  assign count = cnt_q;
  assign wave  = wave_q;
endmodule

// File: rtl/tri_timer_pwm.sv
module tri_timer_pwm import tt_pkg::*; #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] wave_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CH-1:0][1:0]       isr_all, ier_all;
  logic [NUM_CH-1:0]            halt_d, restart_s, wave_off_q, wrap_all;
  logic [NUM_CH-1:0][BUS_W-1:0] ch_rdata;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CLK   = ADDR_W'(OFS_CLK   + CH_STRIDE*g);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL  + CH_STRIDE*g);
    localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(OFS_CNT   + CH_STRIDE*g);
    localparam logic [ADDR_W-1:0] A_INTV  = ADDR_W'(OFS_INTV  + CH_STRIDE*g);
    localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(OFS_MATCH + CH_STRIDE*g);
    localparam logic [ADDR_W-1:0] A_ISR   = ADDR_W'(OFS_ISR   + CH_STRIDE*g);
    localparam logic [ADDR_W-1:0] A_IER   = ADDR_W'(OFS_IER   + CH_STRIDE*g);

    clk_ctrl_t        clk_q, clk_d;
    cnt_ctrl_t        ctrl_q, ctrl_d;
    logic [CNT_W-1:0] intv_q, intv_d, match_q, match_d, count;
    logic [1:0]       isr_q, isr_d, ier_q, ier_d;
    logic             tick, restart, wrap_evt, match_evt, rd_isr;

    // next-state for the channel's registers
    always_comb begin
      clk_d   = clk_q;
      ctrl_d  = ctrl_q;
      intv_d  = intv_q;
      match_d = match_q;
      ier_d   = ier_q;
      restart = 1'b0;
      rd_isr  = bus_rd && (bus_addr == A_ISR);
      if (bus_wr) begin
        if (bus_addr == A_CLK)   clk_d   = clk_ctrl_t'(bus_wdata[5:0]);
        if (bus_addr == A_INTV)  intv_d  = bus_wdata[CNT_W-1:0];
        if (bus_addr == A_MATCH) match_d = bus_wdata[CNT_W-1:0];
        if (bus_addr == A_IER)   ier_d   = bus_wdata[1:0];
        if (bus_addr == A_CTRL) begin
          ctrl_d         = cnt_ctrl_t'(bus_wdata[6:0]);
          restart        = bus_wdata[4];
          ctrl_d.restart = 1'b0;
          ctrl_d.spare   = 1'b0;
        end
      end
      // an event on the clearing edge survives the clear
      isr_d = (rd_isr ? 2'b00 : isr_q) | {match_evt, wrap_evt};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        clk_q   <= '0;
        ctrl_q  <= CTRL_RST;
        intv_q  <= '0;
        match_q <= '0;
        ier_q   <= '0;
        isr_q   <= '0;
      end else begin
        clk_q   <= clk_d;
        ctrl_q  <= ctrl_d;
        intv_q  <= intv_d;
        match_q <= match_d;
        ier_q   <= ier_d;
        isr_q   <= isr_d;
      end
    end

    tt_prescaler #(.SEL_W(SEL_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (!ctrl_d.halt),
      .restart (restart),
      .div_en  (clk_d.div_en),
      .div_sel (clk_d.div_sel),
      .tick    (tick)
    );

    tt_channel #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .restart   (restart),
      .ctrl      (ctrl_d),
      .intv      (intv_q),
      .match_val (match_q),
      .count     (count),
      .wave      (wave_o[g]),
      .wrap_evt  (wrap_evt),
      .match_evt (match_evt)
    );

    always_comb begin
      ch_rdata[g] = '0;
      if (bus_addr == A_CLK)   ch_rdata[g] = BUS_W'(clk_q);
      if (bus_addr == A_CTRL)  ch_rdata[g] = BUS_W'(ctrl_q);
      if (bus_addr == A_CNT)   ch_rdata[g] = BUS_W'(count);
      if (bus_addr == A_INTV)  ch_rdata[g] = BUS_W'(intv_q);
      if (bus_addr == A_MATCH) ch_rdata[g] = BUS_W'(match_q);
      if (bus_addr == A_ISR)   ch_rdata[g] = BUS_W'(isr_q);
      if (bus_addr == A_IER)   ch_rdata[g] = BUS_W'(ier_q);
    end

    assign irq_o[g]      = |(isr_q & ier_q);
    assign cnt_all[g]    = count;
    assign isr_all[g]    = isr_q;
    assign ier_all[g]    = ier_q;
    assign halt_d[g]     = ctrl_d.halt;
    assign restart_s[g]  = restart;
    assign wave_off_q[g] = ctrl_q.wave_off;
    assign wrap_all[g]   = wrap_evt;
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      bus_rdata = bus_rdata | ch_rdata[c];
    end
    if (!bus_rd) bus_rdata = '0;
  end
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_all,
  input logic [NUM_CH-1:0][1:0]       isr_all,
  input logic [NUM_CH-1:0][1:0]       ier_all,
  input logic [NUM_CH-1:0]            halt_d,
  input logic [NUM_CH-1:0]            restart_s,
  input logic [NUM_CH-1:0]            wave_off_q,
  input logic [NUM_CH-1:0]            wrap_all,
  input logic [NUM_CH-1:0]            wave_o,
  input logic [NUM_CH-1:0]            irq_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_all[g] != $past(cnt_all[g])) |->
        (cnt_all[g] == $past(cnt_all[g]) + 1'b1) || (cnt_all[g] == '0)); // R3
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(halt_d[g]) && !$past(restart_s[g])) |-> $stable(cnt_all[g])); // R4
    AST_WAVE_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      wave_off_q[g] |-> !wave_o[g]); // R8
    AST_WRAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wrap_all[g]) |-> isr_all[g][0]); // R9
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_all[g] == 2'b00) |-> !irq_o[g]); // R10
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(restart_s[g]) |-> (cnt_all[g] == '0)); // R11
  end
endmodule

bind tri_timer_pwm tt_checker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_all    (cnt_all),
  .isr_all    (isr_all),
  .ier_all    (ier_all),
  .halt_d     (halt_d),
  .restart_s  (restart_s),
  .wave_off_q (wave_off_q),
  .wrap_all   (wrap_all),
  .wave_o     (wave_o),
  .irq_o      (irq_o)
);

// File: tb/tri_timer_pwm_tb.sv
module tri_timer_pwm_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [2:0]  wave_o, irq_o;

  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    int          req;
    logic [7:0]  addr;
    logic [31:0] exp;
  } sb_item_t;
  sb_item_t sb[$];

  always #2 clk = ~clk; // 250 MHz

  tri_timer_pwm u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wave_o    (wave_o),
    .irq_o     (irq_o)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  // driver: queue the expected word, then issue the read
  task automatic rd(input logic [7:0] a, input logic [31:0] e, input int req);
    sb_item_t it;
    it.req = req; it.addr = a; it.exp = e;
    sb.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    step();
    bus_rd = 1'b0;
  endtask

  // monitor: compare read data mid-cycle, away from the edge
  always @(negedge clk) begin
    sb_item_t got;
    if (bus_rd && rst_n) begin
      if (sb.size() == 0) begin
        check(2, bus_rdata, 32'hDEAD_BEEF);
      end else begin
        got = sb.pop_front();
        check(got.req, bus_rdata, got.exp);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #800000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R1 reset state
    check(1, {29'd0, wave_o}, 32'd0);
    check(1, {29'd0, irq_o}, 32'd0);
    rd(8'h0C, 32'h21, 1);
    rd(8'h18, 32'h0, 1);
    rd(8'h54, 32'h0, 1);
    rd(8'h60, 32'h0, 1);

    // channel 0: period 10, match 4, both interrupts enabled
    wr(8'h24, 32'd9);
    wr(8'h30, 32'd4);
    wr(8'h60, 32'd3);
    wr(8'h0C, 32'h1A);                   // R11 restart, run
    for (int k = 0; k < 12; k++) begin
      check(6, {31'd0, wave_o[0]}, {31'd0, (k % 10) < 4});   // R6
      rd(8'h18, 32'(k % 10), 3);                              // R3
    end
    check(10, {31'd0, irq_o[0]}, 32'd1);                      // R10
    rd(8'h54, 32'h3, 9);                                      // R9
    rd(8'h54, 32'h0, 9);                                      // R9 cleared

    // halt together with restart
    wr(8'h0C, 32'h1B);
    repeat (4) step();
    rd(8'h18, 32'h0, 4);                                      // R4
    rd(8'h0C, 32'h0B, 11);                                    // R11 reads 0

    // inverted polarity
    wr(8'h0C, 32'h5A);
    for (int k = 0; k < 10; k++) begin
      check(7, {31'd0, wave_o[0]}, {31'd0, !((k % 10) < 4)});  // R7
      step();
    end

    // waveform disabled (active-low enable set)
    wr(8'h0C, 32'h3A);
    for (int k = 0; k < 6; k++) begin
      check(8, {31'd0, wave_o[0]}, 32'd0);                     // R8
      step();
    end

    // channel 1: prescaler N=1, one step per 4 clocks
    wr(8'h28, 32'd100);
    wr(8'h04, 32'h03);
    wr(8'h10, 32'h12);
    for (int k = 0; k < 10; k++) begin
      rd(8'h1C, 32'(k / 4), 5);                                // R5
    end
    rd(8'h28, 32'd100, 2);                                     // R2
    rd(8'h04, 32'h03, 2);
    rd(8'h24, 32'd9, 2);
    wr(8'h38, 32'h1234);
    rd(8'h38, 32'h1234, 2);
    rd(8'h30, 32'd4, 2);

    // channel 2: status read lands on the wrap edge
    wr(8'h2C, 32'd5);
    wr(8'h14, 32'h12);
    repeat (5) step();
    rd(8'h5C, 32'h0, 12);                                      // R12
    check(10, {31'd0, irq_o[2]}, 32'd0);                       // R10 masked
    rd(8'h5C, 32'h1, 12);                                      // R12 retained
    rd(8'h5C, 32'h0, 9);

    step();
    finish_run();
  end
endmodule